// File: doc/BRIEF.md
# Display sync output conditioner

This block is the control and timing-signal stage of a parallel RGB display output. It keeps one control word behind a small word-addressed register bus. It takes horizontal sync, vertical sync and data-enable from an upstream timing generator, and it drives three conditioned pins: hsync, vsync and output-enable.

Each of the three pins has its own force-off, polarity inversion and falling-edge launch control. The output-enable pin carries either data-enable or a composite sync built from the two sync inputs. The block also drives a pixel clock output whose polarity can be inverted. It passes the channel-order and pixel-format fields straight to a downstream pixel packer.

A port-enable bit gates the whole path. Writing that bit from 0 to 1 clears the pipeline, so no stale timing state is left over from an earlier enable.

Top module: `sync_cond`

## Requirements
- R1: The control register is at address 0. It resets to zero. A write to address 0 stores bits 16:0 of the write data, and a read of address 0 returns those bits with bits 31:17 as zero. A write to any other address leaves the register unchanged.
- R2: A read of any address other than 0 returns the constant 0x00647069.
- R3: While control bit 0 (port enable) is 0, the hsync, vsync, output-enable and pixel clock outputs are all 0, and the timing inputs have no effect on later outputs.
- R4: With the falling-edge bits clear, each sync/enable output changes at the rising clock edge that samples its input, one clock after the input is applied.
- R5: Control bits 3, 2 and 1 force hsync, vsync and output-enable respectively to 0, whatever their invert bits hold.
- R6: Control bits 9, 8 and 7 invert hsync, vsync and output-enable respectively.
- R7: Control bits 6, 5 and 4 make hsync, vsync and output-enable respectively change at the falling clock edge that follows the capturing rising edge, instead of at the rising edge itself.
- R8: Control bit 10 set makes the pixel clock output the inverse of the clock; when it is clear, the output follows the clock.
- R9: With control bit 16 set, output-enable is sourced from data-enable. With it clear, output-enable is sourced from NOT(hsync XOR vsync), and data-enable is ignored.
- R10: The channel-order output equals control bits 15:14, and the pixel-format output equals control bits 13:11.
- R11: A write that sets the enable bit while it is 0 clears the rising-edge pipeline at that edge. A write of 1 while the port is already enabled does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| hs_in | input | 1 | Horizontal sync from timing generator |
| vs_in | input | 1 | Vertical sync from timing generator |
| de_in | input | 1 | Data enable from timing generator |
| hs_out | output | 1 | Conditioned hsync pin |
| vs_out | output | 1 | Conditioned vsync pin |
| oe_out | output | 1 | Conditioned output-enable pin |
| pclk_out | output | 1 | Pixel clock with selectable polarity |
| chan_order | output | 2 | Channel order to packer |
| pix_fmt | output | 3 | Pixel format to packer |

## Verification
The conditioning path is driven with every combination of hsync, vsync and data-enable. This is repeated under plain, inverted, forced-off, mixed force-off plus invert, and composite-sync settings, so that a swapped bit index or a wrong processing order shows up on a specific pin. Samples are taken just after the rising edge and again just after the falling edge. This separates rising-launched from falling-launched outputs and shows the one-clock latency. The restart test leaves a stale 1 in the pipeline while the port is disabled, then re-enables it. This tells a true 0-to-1 restart apart from a rewrite of an already-set enable bit.

// File: rtl/sync_cond.sv
module sync_cond #(
  parameter int          ADDR_W  = 4,
  parameter logic [31:0] ID_WORD = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic              hs_out,
  output logic              vs_out,
  output logic              oe_out,
  output logic              pclk_out,
  output logic [1:0]        chan_order,
  output logic [2:0]        pix_fmt
);
  localparam int CW = 17;

  logic [CW-1:0] ctrl_q;
  logic [2:0]    src, lvl, rise_q, fall_q, pins;

  wire sel_ctrl = (bus_addr == '0);
  wire ctrl_wr  = bus_wr & sel_ctrl;
  wire en       = ctrl_q[0];
  wire restart  = ctrl_wr & bus_wdata[0] & ~en;

  wire [2:0] dis  = ctrl_q[3:1];
  wire [2:0] fall = ctrl_q[6:4];
  wire [2:0] inv  = ctrl_q[9:7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[CW-1:0];

  assign bus_rdata = sel_ctrl ? {{(32-CW){1'b0}}, ctrl_q} : ID_WORD;

  // index 2: hsync, 1: vsync, 0: output-enable
  assign src = {hs_in, vs_in, ctrl_q[16] ? de_in : ~(hs_in ^ vs_in)};
  assign lvl = ~dis & (src ^ inv);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rise_q <= '0;
    else if (restart) rise_q <= '0;
    else if (en)      rise_q <= lvl;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rise_q;

  assign pins = {3{en}} & ((fall & fall_q) | (~fall & rise_q));
  assign {hs_out, vs_out, oe_out} = pins;
  assign pclk_out   = en & (clk ^ ctrl_q[10]);
  assign chan_order = ctrl_q[15:14];
  assign pix_fmt    = ctrl_q[13:11];

  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(bus_wdata[CW-1:0]));

  assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en && !restart) |-> $stable(rise_q));

  assert_hs_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && !restart && !dis[2] && !inv[2]) |-> rise_q[2] == $past(hs_in));

  assert_forced_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && dis == 3'b111) |-> rise_q == 3'b000);

  assert_restart_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> rise_q == 3'b000);
endmodule

// File: tb/tb_sync_cond.sv
module tb_sync_cond;
  localparam int PERIOD = 10;
  localparam logic [31:0] ID = 32'h0064_7069;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic hs_in = 0, vs_in = 0, de_in = 0;
  logic hs_out, vs_out, oe_out, pclk_out;
  logic [1:0] chan_order;
  logic [2:0] pix_fmt;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  sync_cond dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_in(hs_in), .vs_in(vs_in),
    .de_in(de_in), .hs_out(hs_out), .vs_out(vs_out), .oe_out(oe_out),
    .pclk_out(pclk_out), .chan_order(chan_order), .pix_fmt(pix_fmt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = '0;
  endtask

  task automatic rise2(); @(posedge clk); #2; endtask
  task automatic fall2(); @(negedge clk); #2; endtask

  function automatic logic [2:0] model(input logic [16:0] c, input logic h, v, d);
    logic [2:0] s, r;
    s = {h, v, c[16] ? d : ~(h ^ v)};
    r = ~c[3:1] & (s ^ c[9:7]);
    return c[0] ? r : 3'b000;
  endfunction

  task automatic sweep(input string req, input logic [16:0] c);
    write(0, {15'd0, c});
    for (int p = 0; p < 8; p++) begin
      {hs_in, vs_in, de_in} = p[2:0];
      rise2();
      fall2();
      check(req, {hs_out, vs_out, oe_out}, model(c, p[2], p[1], p[0]));
    end
  endtask

  task automatic t_reset();
    bus_addr = 0; #1;
    check("R1 reset value", bus_rdata, 0);
    check("R3 reset pins", {hs_out, vs_out, oe_out, pclk_out}, 0);
  endtask

  task automatic t_regs();
    write(0, 32'hFFFF_FFFE);
    bus_addr = 0; #1;
    check("R1 readback", bus_rdata, 32'h0001_FFFE);
    check("R10 order", chan_order, 3);
    check("R10 format", pix_fmt, 7);
    write(3, 32'h0000_5A5A);
    bus_addr = 0; #1;
    check("R1 other-address write ignored", bus_rdata, 32'h0001_FFFE);
    foreach (bus_addr[i]) begin
      bus_addr = 4'(1 << i); #1;
      check("R2 id read", bus_rdata, ID);
    end
    bus_addr = 4'hF; #1;
    check("R2 id read top", bus_rdata, ID);
    write(0, 32'h0000_9000);
    check("R10 order 2", chan_order, 2);
    check("R10 format 2", pix_fmt, 2);
  endtask

  task automatic t_disabled();
    write(0, 32'h0001_0000);
    {hs_in, vs_in, de_in} = 3'b111;
    rise2();
    check("R3 pins high phase", {hs_out, vs_out, oe_out, pclk_out}, 0);
    fall2();
    check("R3 pins low phase", {hs_out, vs_out, oe_out, pclk_out}, 0);
  endtask

  task automatic t_latency();
    write(0, 32'h0001_0001);
    {hs_in, vs_in, de_in} = 3'b000;
    rise2(); rise2();
    {hs_in, vs_in, de_in} = 3'b101;
    #4;
    check("R4 not before edge", {hs_out, vs_out, oe_out}, 3'b000);
    rise2();
    check("R4 at rising edge", {hs_out, vs_out, oe_out}, 3'b101);
  endtask

  task automatic t_fall();
    write(0, 32'h0001_0071);
    {hs_in, vs_in, de_in} = 3'b000;
    rise2(); rise2();
    {hs_in, vs_in, de_in} = 3'b111;
    rise2();
    check("R7 held after rising edge", {hs_out, vs_out, oe_out}, 3'b000);
    fall2();
    check("R7 changes at falling edge", {hs_out, vs_out, oe_out}, 3'b111);
    write(0, 32'h0001_0021);
    {hs_in, vs_in, de_in} = 3'b000;
    rise2(); rise2();
    {hs_in, vs_in, de_in} = 3'b111;
    rise2();
    check("R7 only vsync delayed", {hs_out, vs_out, oe_out}, 3'b101);
  endtask

  task automatic t_pclk();
    write(0, 32'h0000_0001);
    rise2(); check("R8 normal high phase", pclk_out, 1);
    fall2(); check("R8 normal low phase", pclk_out, 0);
    write(0, 32'h0000_0401);
    rise2(); check("R8 inverted high phase", pclk_out, 0);
    fall2(); check("R8 inverted low phase", pclk_out, 1);
  endtask

  task automatic t_restart();
    write(0, 32'h0001_0001);
    {hs_in, vs_in, de_in} = 3'b100;
    rise2(); rise2();
    check("R11 primed", hs_out, 1);
    write(0, 32'h0001_0000);
    #1;
    check("R3 disabled gate", hs_out, 0);
    write(0, 32'h0001_0001);
    #1;
    check("R11 pipeline cleared", hs_out, 0);
    rise2();
    check("R11 capture resumes", hs_out, 1);
    write(0, 32'h0001_0001);
    #1;
    check("R11 rewrite keeps state", hs_out, 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 2);
    t_reset();
    rst_n = 1;
    t_regs();
    t_disabled();
    t_latency();
    sweep("R4 plain", 17'h1_0001);
    sweep("R6 invert", 17'h1_0381);
    sweep("R5 forced off with invert", 17'h1_038F);
    sweep("R5 R6 hsync off only", 17'h1_0389);
    sweep("R9 composite sync", 17'h0_0001);
    sweep("R9 composite inverted", 17'h0_0081);
    t_fall();
    t_pclk();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule